// File: doc/BRIEF.md
# HDLC Receive Frame Formatter

This block sits behind an HDLC receiver that has already located the flags and removed the inserted zero bits. It receives whole bytes marked with first-byte and last-byte tags, splits every frame into its address field, its body and its trailing two-byte check sequence, and writes the selected bytes into a receive FIFO through a simple byte write port. Configuration inputs decide whether the address bytes and the received check sequence go into the FIFO or are dropped.

The CRC-ITU-T check runs over every received byte in all modes, whether the check sequence is kept or not. Because the end of the frame is known only when the last-byte tag arrives, the block holds the two most recent bytes back. When the frame ends, the two held bytes are treated as the check sequence. After the kept bytes, the block always appends one status byte. That status byte carries the end-of-frame tag. An abort marker ends the frame at once, and the block then writes only a status byte with the abort bit set.

Top module: `hdlc_rx_formatter`

## Requirements
- R1: After reset, `wr_valid` and `wr_last` are low, and they stay low until a frame has been accepted.
- R2: The first 1 byte of a frame, or the first 2 bytes when `cfg_addr_two` is 1, form the address field. These bytes are written only when `cfg_addr_keep` is 1 and are dropped when it is 0.
- R3: Bytes that follow the address field and come before the final two bytes are always written, in the order they arrived.
- R4: When the last-byte tag arrives, the two most recent bytes of the frame (or the single byte of a one-byte frame) are the check field. They are written in arrival order only when `cfg_crc_keep` is 1, after all body bytes and before the status byte.
- R5: Each completed frame ends with exactly one status byte, and `wr_last` is 1 on that byte. No other written byte has `wr_last` set.
- R6: Status bit 5 is 1 when a CRC with reflected polynomial 0x8408, preset to 0xFFFF and run over all received bytes including the check field, ends at 0xF0B8. This holds in every `cfg_crc_keep` setting.
- R7: Status bit 7 (valid) is 1 when the frame length is at least the address length plus 2 and no abort occurred. Status bit 0 (short) is 1, with bit 7 clear, when a completed frame is shorter than that. Bits 6, 3, 2 and 1 are always 0.
- R8: A cycle with `rx_abort` high inside a frame drops all bytes still held. The only write that follows is the status byte 0x10 with `wr_last`, which appears one cycle after the cycle that follows the abort edge. Any byte offered in the same cycle as `rx_abort` is ignored.
- R9: Writes are registered. A body or address byte is written in the cycle after the byte two positions later is accepted. The kept check bytes follow in the first and second cycles after the last-byte edge, and the status byte follows in the third.
- R10: Bytes offered outside a frame without the first-byte tag are ignored. `rx_abort` outside a frame is ignored. Neither produces a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | A received byte is offered this cycle |
| rx_byte | input | 8 | Received byte |
| rx_first | input | 1 | Offered byte is the first of a frame |
| rx_final | input | 1 | Offered byte is the last of a frame |
| rx_abort | input | 1 | Abort marker for the current frame |
| cfg_addr_keep | input | 1 | Write the address bytes into the FIFO |
| cfg_addr_two | input | 1 | Address field is 2 bytes (1 byte when low) |
| cfg_crc_keep | input | 1 | Write the received check bytes into the FIFO |
| wr_valid | output | 1 | FIFO write strobe |
| wr_data | output | 8 | Byte written to the FIFO |
| wr_last | output | 1 | Written byte is the frame's status byte |

## Verification
The hardest situations to reach from the ports are the frames where the held check bytes overlap the address field or where the frame ends before the hold line has filled. These are frames one, two and three bytes long, under both address lengths. The stimulus sends each of these lengths under both address modes, with the check field kept and with it dropped. It also sends aborts on the cycle right after the first byte, when one byte is held, and deep inside a frame, when two bytes are held. Body bytes arrive with idle gaps between them as well as back to back, so the check also covers the case where a hold-line shift is separated from the write it causes.

// File: rtl/hdlc_fmt_pkg.sv
package hdlc_fmt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RUN,
    ST_CHK0,
    ST_CHK1,
    ST_STAT
  } fmt_state_e;

  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned CRC_W     = 16;
  localparam int unsigned SB_VALID  = 7;
  localparam int unsigned SB_CRCOK  = 5;
  localparam int unsigned SB_ABORT  = 4;
  localparam int unsigned SB_SHORT  = 0;

  localparam logic [CRC_W-1:0] CRC_PRESET  = 16'hFFFF;
  localparam logic [CRC_W-1:0] CRC_RESIDUE = 16'hF0B8;
  localparam logic [CRC_W-1:0] CRC_POLY_R  = 16'h8408;

  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                input logic [BYTE_W-1:0] b);
    logic [CRC_W-1:0] r;
    r = c;
    for (int i = 0; i < BYTE_W; i++) begin
      if (r[0] ^ b[i]) r = (r >> 1) ^ CRC_POLY_R;
      else             r = r >> 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/hdlc_fmt_crc.sv
module hdlc_fmt_crc
  import hdlc_fmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              restart,
  input  logic [BYTE_W-1:0] data,
  output logic [CRC_W-1:0]  crc_q
);

  logic [CRC_W-1:0] crc_d;

  always_comb begin
    crc_d = crc_q;
    if (en) crc_d = crc_step(restart ? CRC_PRESET : crc_q, data);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= CRC_PRESET;
    else        crc_q <= crc_d;
  end

  // R6
  crc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(crc_q));

endmodule

// File: rtl/hdlc_fmt_hold.sv
module hdlc_fmt_hold
  import hdlc_fmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              first,
  input  logic [BYTE_W-1:0] data,
  output logic [BYTE_W-1:0] old_q,
  output logic [BYTE_W-1:0] new_q,
  output logic [1:0]        fill_q,
  output logic              pop
);

  logic [BYTE_W-1:0] old_d, new_d;
  logic [1:0]        fill_d;

  assign pop = en && !first && (fill_q == 2'd2);

  always_comb begin
    old_d  = old_q;
    new_d  = new_q;
    fill_d = fill_q;
    if (en) begin
      new_d  = data;
      old_d  = new_q;
      if (first)               fill_d = 2'd1;
      else if (fill_q != 2'd2) fill_d = fill_q + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      old_q  <= '0;
      new_q  <= '0;
      fill_q <= '0;
    end else begin
      old_q  <= old_d;
      new_q  <= new_d;
      fill_q <= fill_d;
    end
  end

  // R4
  fill_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q != 2'd3);

  // R4
  fill_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && first) |=> (fill_q == 2'd1));

  // R3
  shift_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (old_q == $past(new_q)));

endmodule

// File: rtl/hdlc_fmt_ctrl.sv
module hdlc_fmt_ctrl
  import hdlc_fmt_pkg::*;
#(
  parameter int unsigned CNT_W = 12
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic              rx_first,
  input  logic              rx_final,
  input  logic              rx_abort,
  input  logic              cfg_addr_keep,
  input  logic              cfg_addr_two,
  input  logic              cfg_crc_keep,
  input  logic              pop,
  input  logic [BYTE_W-1:0] old_b,
  input  logic [BYTE_W-1:0] new_b,
  input  logic [1:0]        fill,
  input  logic [CRC_W-1:0]  crc,
  output logic              take,
  output logic              wr_valid,
  output logic [BYTE_W-1:0] wr_data,
  output logic              wr_last
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  fmt_state_e        state_q, state_d;
  logic [CNT_W-1:0]  len_q, len_d;
  logic              abt_q, abt_d;
  logic              wv_d, wl_d;
  logic [BYTE_W-1:0] wd_d;
  logic [CNT_W-1:0]  addr_len, min_len;
  logic              in_frame, abort_take, is_addr, too_short;
  logic [BYTE_W-1:0] status;

  assign in_frame   = (state_q == ST_RUN);
  assign abort_take = rx_abort && in_frame;
  assign take       = rx_valid && !rx_abort &&
                      (rx_first ? (state_q == ST_IDLE || in_frame) : in_frame);

  assign addr_len  = cfg_addr_two ? CNT_W'(2) : CNT_W'(1);
  assign min_len   = addr_len + CNT_W'(2);
  assign is_addr   = (len_q < min_len);
  assign too_short = (len_q < min_len);

  always_comb begin
    status = '0;
    status[SB_VALID] = !abt_q && !too_short;
    status[SB_CRCOK] = !abt_q && (crc == CRC_RESIDUE);
    status[SB_ABORT] = abt_q;
    status[SB_SHORT] = !abt_q && too_short;
  end

  always_comb begin
    state_d = state_q;
    len_d   = len_q;
    abt_d   = abt_q;
    if (take) begin
      if (rx_first)            len_d = CNT_W'(1);
      else if (len_q != CNT_MAX) len_d = len_q + CNT_W'(1);
    end
    case (state_q)
      ST_IDLE: if (take) state_d = rx_final ? ST_CHK0 : ST_RUN;
      ST_RUN: begin
        if (abort_take) begin
          state_d = ST_STAT;
          abt_d   = 1'b1;
        end else if (take && rx_final) begin
          state_d = ST_CHK0;
        end
      end
      ST_CHK0: state_d = ST_CHK1;
      ST_CHK1: state_d = ST_STAT;
      ST_STAT: begin
        state_d = ST_IDLE;
        abt_d   = 1'b0;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    wv_d = 1'b0;
    wd_d = old_b;
    wl_d = 1'b0;
    case (state_q)
      ST_IDLE, ST_RUN: if (pop && (!is_addr || cfg_addr_keep)) wv_d = 1'b1;
      ST_CHK0: if (cfg_crc_keep && fill == 2'd2) wv_d = 1'b1;
      ST_CHK1: begin
        wd_d = new_b;
        if (cfg_crc_keep && fill != 2'd0) wv_d = 1'b1;
      end
      ST_STAT: begin
        wv_d = 1'b1;
        wd_d = status;
        wl_d = 1'b1;
      end
      default: wv_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      len_q    <= '0;
      abt_q    <= 1'b0;
      wr_valid <= 1'b0;
      wr_data  <= '0;
      wr_last  <= 1'b0;
    end else begin
      state_q  <= state_d;
      len_q    <= len_d;
      abt_q    <= abt_d;
      wr_valid <= wv_d;
      wr_data  <= wd_d;
      wr_last  <= wl_d;
    end
  end

  // R5
  stat_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STAT) |=> (wr_valid && wr_last));

  // R8
  abort_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_take |=> ##1 (wr_valid && wr_last && wr_data == 8'h10));

  // R4
  crc_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_CHK0 || state_q == ST_CHK1) && !cfg_crc_keep) |=> !wr_valid);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !take) |=> !wr_valid);

  // R7
  short_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_last && wr_data[SB_SHORT]) |-> !wr_data[SB_VALID]);

endmodule

// File: rtl/hdlc_rx_formatter.sv
module hdlc_rx_formatter
  import hdlc_fmt_pkg::*;
#(
  parameter int unsigned CNT_W = 12
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  input  logic       rx_first,
  input  logic       rx_final,
  input  logic       rx_abort,
  input  logic       cfg_addr_keep,
  input  logic       cfg_addr_two,
  input  logic       cfg_crc_keep,
  output logic       wr_valid,
  output logic [7:0] wr_data,
  output logic       wr_last
);

  logic              rst_meta, rst_sync_n;
  logic              take, pop;
  logic [BYTE_W-1:0] old_b, new_b;
  logic [1:0]        fill;
  logic [CRC_W-1:0]  crc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  hdlc_fmt_crc u_crc (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .en      (take),
    .restart (rx_first),
    .data    (rx_byte),
    .crc_q   (crc)
  );

  hdlc_fmt_hold u_hold (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .en     (take),
    .first  (rx_first),
    .data   (rx_byte),
    .old_q  (old_b),
    .new_q  (new_b),
    .fill_q (fill),
    .pop    (pop)
  );

  hdlc_fmt_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .rx_valid      (rx_valid),
    .rx_first      (rx_first),
    .rx_final      (rx_final),
    .rx_abort      (rx_abort),
    .cfg_addr_keep (cfg_addr_keep),
    .cfg_addr_two  (cfg_addr_two),
    .cfg_crc_keep  (cfg_crc_keep),
    .pop           (pop),
    .old_b         (old_b),
    .new_b         (new_b),
    .fill          (fill),
    .crc           (crc),
    .take          (take),
    .wr_valid      (wr_valid),
    .wr_data       (wr_data),
    .wr_last       (wr_last)
  );

endmodule

// File: tb/sim_hdlc_rx_formatter.sv
module sim_hdlc_rx_formatter;

  localparam int CLK_PERIOD = 10;
  localparam int MAXC       = 8192;

  logic       clk, rst_n;
  logic       rx_valid, rx_first, rx_final, rx_abort;
  logic [7:0] rx_byte;
  logic       cfg_addr_keep, cfg_addr_two, cfg_crc_keep;
  logic       wr_valid, wr_last;
  logic [7:0] wr_data;

  hdlc_rx_formatter u0 (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_first(rx_first), .rx_final(rx_final), .rx_abort(rx_abort),
    .cfg_addr_keep(cfg_addr_keep), .cfg_addr_two(cfg_addr_two),
    .cfg_crc_keep(cfg_crc_keep), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_last(wr_last)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int    n_checks = 0;
  int    n_fails  = 0;
  bit    done     = 0;
  int    cyc      = 0;
  logic        exp_v [MAXC];
  logic [7:0]  exp_d [MAXC];
  logic        exp_l [MAXC];
  string       exp_t [MAXC];
  string       cur_tag = "R9";
  bit          m_in_frame = 0;
  logic [7:0]  mq[$];
  logic [7:0]  fq[$];

  function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ b[i]) r = (r >> 1) ^ 16'h8408;
      else             r = r >> 1;
    end
    return r;
  endfunction

  task automatic put(input int slot, input logic [7:0] d, input logic l, input string t);
    if (slot < MAXC) begin
      exp_v[slot] = 1'b1;
      exp_d[slot] = d;
      exp_l[slot] = l;
      exp_t[slot] = t;
    end
  endtask

  task automatic model(input logic v, input logic [7:0] d, input logic s,
                       input logic e, input logic a);
    int alen = cfg_addr_two ? 2 : 1;
    if (exp_t[cyc] == "") exp_t[cyc] = cur_tag;
    if (a) begin
      if (m_in_frame) begin
        put(cyc + 1, 8'h10, 1'b1, "R8");
        m_in_frame = 0;
        mq.delete();
      end
    end else if (v && (s || m_in_frame)) begin
      if (s) begin
        mq.delete();
        m_in_frame = 1;
      end
      mq.push_back(d);
      if (mq.size() >= 3) begin
        int k = mq.size() - 3;
        if (k < alen) begin
          if (cfg_addr_keep) put(cyc, mq[k], 1'b0, "R2");
        end else begin
          put(cyc, mq[k], 1'b0, "R3");
        end
      end
      if (e) begin
        int n = mq.size();
        logic [15:0] r = 16'hFFFF;
        logic [7:0]  st = 8'h00;
        m_in_frame = 0;
        if (cfg_crc_keep) begin
          if (n >= 2) begin
            put(cyc + 1, mq[n-2], 1'b0, "R4");
            put(cyc + 2, mq[n-1], 1'b0, "R4");
          end else begin
            put(cyc + 2, mq[0], 1'b0, "R4");
          end
        end
        for (int i = 0; i < n; i++) r = crc_upd(r, mq[i]);
        if (n < alen + 2) st[0] = 1'b1;
        else              st[7] = 1'b1;
        if (r == 16'hF0B8) st[5] = 1'b1;
        put(cyc + 3, st, 1'b1, (n < alen + 2) ? "R5,R7" : "R5,R6");
      end
    end
  endtask

  task automatic check_slot();
    n_checks++;
    if (wr_valid !== exp_v[cyc] ||
        (exp_v[cyc] && (wr_data !== exp_d[cyc] || wr_last !== exp_l[cyc]))) begin
      n_fails++;
      $display("FAIL %s cycle %0d: got v=%b d=%02h l=%b, want v=%b d=%02h l=%b",
               exp_t[cyc], cyc, wr_valid, wr_data, wr_last,
               exp_v[cyc], exp_d[cyc], exp_l[cyc]);
    end
  endtask

  task automatic drive(input logic v, input logic [7:0] d, input logic s,
                       input logic e, input logic a);
    rx_valid = v; rx_byte = d; rx_first = s; rx_final = e; rx_abort = a;
    model(v, d, s, e, a);
    @(posedge clk);
    @(negedge clk);
    check_slot();
    if (cyc < MAXC - 4) cyc++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic build(input int n, input int seed, input bit good);
    logic [15:0] r = 16'hFFFF;
    fq.delete();
    for (int i = 0; i < n; i++) begin
      logic [7:0] b = 8'((seed * 37 + i * 13 + 5) & 8'hFF);
      fq.push_back(b);
      r = crc_upd(r, b);
    end
    r = ~r;
    if (!good) r = r ^ 16'h0100;
    fq.push_back(r[7:0]);
    fq.push_back(r[15:8]);
  endtask

  task automatic build_raw(input int n, input int seed);
    fq.delete();
    for (int i = 0; i < n; i++) fq.push_back(8'((seed * 11 + i * 29 + 3) & 8'hFF));
  endtask

  task automatic send(input int gap_every, input int abort_after);
    int last = fq.size() - 1;
    for (int i = 0; i < fq.size(); i++) begin
      if (abort_after >= 0 && i == abort_after) begin
        drive(1'b1, 8'h5A, 1'b0, 1'b0, 1'b1);
        idle(4);
        return;
      end
      drive(1'b1, fq[i], i == 0, i == last, 1'b0);
      if (gap_every > 0 && (i % gap_every) == 0 && i != last) idle(1);
    end
    idle(4);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: got timeout, want completion");
    finish_up();
  end

  initial begin
    for (int i = 0; i < MAXC; i++) begin
      exp_v[i] = 1'b0; exp_d[i] = 8'h00; exp_l[i] = 1'b0; exp_t[i] = "";
    end
    rst_n = 1'b0;
    rx_valid = 0; rx_byte = 0; rx_first = 0; rx_final = 0; rx_abort = 0;
    cfg_addr_keep = 0; cfg_addr_two = 0; cfg_crc_keep = 0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    // R1: quiet after reset
    n_checks++;
    if (wr_valid !== 1'b0 || wr_last !== 1'b0) begin
      n_fails++;
      $display("FAIL R1: got v=%b l=%b, want v=0 l=0", wr_valid, wr_last);
    end
    cur_tag = "R1";
    idle(3);

    // R2 R3 R4 R6 R9: all option combinations, good frames
    cur_tag = "R9";
    for (int c = 0; c < 8; c++) begin
      cfg_addr_two  = c[0];
      cfg_addr_keep = c[1];
      cfg_crc_keep  = c[2];
      build(6, c, 1'b1);
      send((c % 3 == 1) ? 2 : 0, -1);
    end

    // R6: corrupted check field, both store settings
    for (int c = 0; c < 2; c++) begin
      cfg_crc_keep = c[0]; cfg_addr_two = 1'b0; cfg_addr_keep = 1'b1;
      build(5, 20 + c, 1'b0);
      send(0, -1);
    end

    // R7: short frames, every tiny length, both address lengths and store modes
    for (int c = 0; c < 4; c++) begin
      cfg_addr_two = c[0]; cfg_crc_keep = c[1]; cfg_addr_keep = 1'b1;
      for (int n = 1; n <= 4; n++) begin
        build_raw(n, n + c * 4);
        send(0, -1);
      end
    end
    cfg_addr_two = 1'b0; cfg_crc_keep = 1'b1;
    build(0, 40, 1'b1);
    send(0, -1);

    // R8: abort with one byte held and deep in a frame
    cfg_addr_keep = 1'b1; cfg_crc_keep = 1'b1; cfg_addr_two = 1'b1;
    build(8, 50, 1'b1);
    send(0, 1);
    build(8, 51, 1'b1);
    send(1, 7);
    build(8, 52, 1'b1);
    send(0, 10);

    // R10: stray bytes and abort outside a frame
    cur_tag = "R10";
    drive(1'b1, 8'hC3, 1'b0, 1'b0, 1'b0);
    drive(1'b1, 8'h3C, 1'b0, 1'b1, 1'b0);
    drive(1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
    drive(1'b1, 8'h99, 1'b1, 1'b0, 1'b1);
    idle(4);
    cur_tag = "R9";
    build(4, 60, 1'b1);
    send(0, -1);

    // R5: back-to-back frames with the minimum gap
    cfg_addr_keep = 1'b0; cfg_crc_keep = 1'b0; cfg_addr_two = 1'b0;
    for (int f = 0; f < 3; f++) begin
      build(3 + f, 70 + f, 1'b1);
      for (int i = 0; i < fq.size(); i++)
        drive(1'b1, fq[i], i == 0, i == fq.size() - 1, 1'b0);
      idle(3);
    end
    idle(4);
    finish_up();
  end

endmodule